// File: doc/BRIEF.md
# Five-Stage Pipelined Micro-CPU Core

This block is a small in-order processor core with five pipeline stages: fetch, decode, a dual-increment execute stage, data-memory access and write-back. It runs a nine-instruction set on a 16-bit datapath with a sixteen-entry register file. The core drives a combinational instruction-memory read port and a data-memory port that has an address, write data, read data and separate read and write strobes. Branches are resolved in the decode stage. Register dependencies are covered by forwarding wherever the value already exists somewhere in the pipe. The decode stage holds only when no forwarding path can deliver the value in time.

Each instruction word is 32 bits. A one-hot opcode sits in the top byte, followed by a destination register field, a source register field and a 16-bit immediate. The immediate serves either as a direct data-memory address or as a branch target. The execute stage holds a chain of two +4 incrementers, and bypass selects skip one or both of them. Because plain stores add nothing, a plain store may pick up its data as late as the memory stage. This lets a store that follows a load run without any hold.

Top module: `cpu5_core`

## Requirements
- R1: While `rst_n` is low, `imem_addr` is 0 and neither data strobe is high. The first fetch after release is from address 0, and every pipeline slot starts as a no-op.
- R2: Instruction bits [31:24] are a one-hot opcode, bit 24 upward: copy, branch-if-zero, add-4, add-8, load, store, store-plus-4, store-plus-8. All zero is a no-op. Bits [23:20] name the destination, bits [19:16] the source and bits [15:0] the immediate J. Copy, add-4 and add-8 write source+0, +4 and +8 to the destination, modulo 2^16.
- R3: Store, store-plus-4 and store-plus-8 write source+0, +4 and +8 to data address J with `dmem_wr` high. Load writes the data word at J to the destination.
- R4: Branch-if-zero loads J into the PC when its source is zero. The instruction fetched behind it is discarded, so a taken branch costs one cycle.
- R5: An instruction in the execute stage receives a copy or add result from the instruction directly ahead of it, or from the one two ahead, without any hold.
- R6: A plain store directly after a load of its source register stores the loaded value, and the pipeline does not hold.
- R7: Any reader of a register other than a plain store or a branch, directly after a load of that register, holds exactly one cycle.
- R8: A branch directly after a copy into its source does not hold. Directly after an add it holds one cycle. Directly after a load it holds two cycles. With one instruction between it and a load it holds one cycle.
- R9: A register written in the write-back stage is seen by a decode-stage read in the same cycle.
- R10: A load raises `dmem_rd` for one cycle with `dmem_addr` equal to J. The two strobes are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| imem_addr | output | 16 | Instruction fetch address (PC) |
| imem_rdata | input | 32 | Instruction word at `imem_addr`, same cycle |
| dmem_addr | output | 16 | Data-memory address from the memory stage |
| dmem_wdata | output | DW | Store data |
| dmem_rdata | input | DW | Load data at `dmem_addr`, same cycle |
| dmem_rd | output | 1 | Load strobe |
| dmem_wr | output | 1 | Store strobe |

## Verification
Assertions check on every cycle that the PC holds while decode is held, and that a taken branch redirects the next fetch to its immediate. They also check that a load result never reaches the execute stage of an instruction that needs it there, that the two data strobes are exclusive, and that fetch restarts at address 0. Only the bench's scenarios can show that stored values are arithmetically right and that the hold counts match R5 to R9. The bench sweeps producer kind, consumer kind, spacing and operand value, including values that wrap to zero.

// File: rtl/cpu5_pkg.sv
`timescale 1ns/1ps
package cpu5_pkg;
    localparam int IW = 32;
    localparam int JW = 16;

    // member order follows instruction bits [31:24], MSB first
    typedef struct packed {
        logic swp8;
        logic swp4;
        logic sw;
        logic lw;
        logic add8;
        logic add4;
        logic bz;
        logic mov;
    } op_t;

    typedef enum logic [1:0] {SRC_FILE, SRC_NEAR, SRC_FAR} fwd_e;

    function automatic logic op_writes(op_t o);
        return o.mov | o.add4 | o.add8 | o.lw;
    endfunction

    function automatic logic op_reads(op_t o);
        return o.mov | o.bz | o.add4 | o.add8 | o.sw | o.swp4 | o.swp8;
    endfunction

    function automatic logic op_alu(op_t o);
        return o.mov | o.add4 | o.add8;
    endfunction

    function automatic logic op_store(op_t o);
        return o.sw | o.swp4 | o.swp8;
    endfunction
endpackage

// File: rtl/cpu5_regfile.sv
`timescale 1ns/1ps
module cpu5_regfile #(
    parameter int DW  = 16,
    parameter int RAW = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [RAW-1:0] rd_idx,
    output logic [DW-1:0]  rd_data,
    input  logic           wr_en,
    input  logic [RAW-1:0] wr_idx,
    input  logic [DW-1:0]  wr_data
);
    localparam int NREG = 1 << RAW;

    logic [DW-1:0] regs [NREG];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (wr_en) begin
            regs[wr_idx] <= wr_data;
        end
    end

    // write-first: a same-cycle write is visible to the decode read
    always_comb begin
        if (wr_en && (wr_idx == rd_idx)) rd_data = wr_data;
        else                             rd_data = regs[rd_idx];
    end
endmodule

// File: rtl/cpu5_hazard.sv
`timescale 1ns/1ps
module cpu5_hazard
    import cpu5_pkg::*;
#(
    parameter int RAW = 4
) (
    input  logic           id_reads,
    input  logic           id_bz,
    input  logic           id_sw,
    input  logic [RAW-1:0] id_rx,
    input  logic           ex_wr,
    input  logic           ex_mov,
    input  logic           ex_lw,
    input  logic [RAW-1:0] ex_rr,
    input  logic           mem_wr,
    input  logic           mem_lw,
    input  logic [RAW-1:0] mem_rr,
    output logic           xm_ex,
    output logic           xm_mem,
    output fwd_e           bz_sel,
    output logic           stall
);
    logic ex_hit, mem_hit, hold_bz, hold_use;

    assign xm_ex   = (id_rx == ex_rr);
    assign xm_mem  = (id_rx == mem_rr);
    assign ex_hit  = xm_ex & ex_wr;
    assign mem_hit = xm_mem & mem_wr;

    // branch needs its operand in decode: only a copy in execute or
    // an arithmetic result in the memory stage can be forwarded
    assign hold_bz  = id_bz & ((ex_hit & ~ex_mov) | (~ex_hit & mem_hit & mem_lw));
    // a plain store collects load data later, in the memory stage
    assign hold_use = id_reads & ~id_bz & ~id_sw & ex_hit & ex_lw;
    assign stall    = hold_bz | hold_use;

    always_comb begin
        if (ex_hit)       bz_sel = SRC_NEAR;
        else if (mem_hit) bz_sel = SRC_FAR;
        else              bz_sel = SRC_FILE;
    end
endmodule

// File: rtl/cpu5_ex12.sv
`timescale 1ns/1ps
module cpu5_ex12
    import cpu5_pkg::*;
#(
    parameter int DW    = 16,
    parameter int STEP  = 4,
    parameter int NSTEP = 2
) (
    input  logic [DW-1:0]                  opnd,
    input  logic                           near_hit,
    input  logic [DW-1:0]                  near_val,
    input  logic                           far_hit,
    input  logic [DW-1:0]                  far_val,
    input  logic [$clog2(NSTEP+1)-1:0]     steps,
    output logic [DW-1:0]                  result
);
    localparam int CW = $clog2(NSTEP+1);

    fwd_e          sel;
    logic [DW-1:0] chain [NSTEP+1];

    always_comb begin
        if (near_hit)     sel = SRC_NEAR;
        else if (far_hit) sel = SRC_FAR;
        else              sel = SRC_FILE;
        unique case (sel)
            SRC_NEAR: chain[0] = near_val;
            SRC_FAR:  chain[0] = far_val;
            default:  chain[0] = opnd;
        endcase
    end

    for (genvar k = 0; k < NSTEP; k++) begin : g_inc
        logic skip;
        assign skip       = (CW'(k) >= steps);
        assign chain[k+1] = skip ? chain[k] : chain[k] + DW'(STEP);
    end

    assign result = chain[NSTEP];
endmodule

// File: rtl/cpu5_core.sv
`timescale 1ns/1ps
module cpu5_core
    import cpu5_pkg::*;
#(
    parameter int DW    = 16,
    parameter int RAW   = 4,
    parameter int STEP  = 4,
    parameter int NSTEP = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [JW-1:0] imem_addr,
    input  logic [IW-1:0] imem_rdata,
    output logic [JW-1:0] dmem_addr,
    output logic [DW-1:0] dmem_wdata,
    input  logic [DW-1:0] dmem_rdata,
    output logic          dmem_rd,
    output logic          dmem_wr
);
    localparam int SCW = $clog2(NSTEP+1);

    // fetch
    logic [JW-1:0] pc;
    // decode
    logic [IW-1:0] id_ir;
    op_t           id_op;
    logic [RAW-1:0] id_rr, id_rx;
    logic [JW-1:0] id_j;
    logic [DW-1:0] rf_q, bz_val;
    logic          xm_ex, xm_mem, stall, taken;
    fwd_e          bz_sel;
    // execute
    op_t           ex_op;
    logic [RAW-1:0] ex_rr, ex_rx;
    logic [JW-1:0] ex_j;
    logic [DW-1:0] ex_opnd, ex_res;
    logic          ex_xm_mem, ex_xm_wb;
    logic [SCW-1:0] ex_steps;
    // memory
    op_t           mem_op;
    logic [RAW-1:0] mem_rr;
    logic [JW-1:0] mem_j;
    logic [DW-1:0] mem_res, mem_sdata;
    logic          mem_xm_wb;
    // write-back
    logic          wb_wr, wb_lw;
    logic [RAW-1:0] wb_rr;
    logic [DW-1:0] wb_res, wb_ld, wb_data;
    logic          unused_bits;

    assign imem_addr = pc;
    assign id_op     = op_t'(id_ir[31:24]);
    assign id_rr     = id_ir[20 +: RAW];
    assign id_rx     = id_ir[16 +: RAW];
    assign id_j      = id_ir[JW-1:0];
    assign wb_data   = wb_lw ? wb_ld : wb_res;

    cpu5_regfile #(.DW(DW), .RAW(RAW)) u_rf (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(id_rx), .rd_data(rf_q),
        .wr_en(wb_wr), .wr_idx(wb_rr), .wr_data(wb_data)
    );

    cpu5_hazard #(.RAW(RAW)) u_hdu (
        .id_reads(op_reads(id_op)), .id_bz(id_op.bz), .id_sw(id_op.sw), .id_rx(id_rx),
        .ex_wr(op_writes(ex_op)), .ex_mov(ex_op.mov), .ex_lw(ex_op.lw), .ex_rr(ex_rr),
        .mem_wr(op_writes(mem_op)), .mem_lw(mem_op.lw), .mem_rr(mem_rr),
        .xm_ex(xm_ex), .xm_mem(xm_mem), .bz_sel(bz_sel), .stall(stall)
    );

    // branch operand: execute-stage copy, then memory-stage result, then file
    always_comb begin
        unique case (bz_sel)
            SRC_NEAR: bz_val = ex_res;
            SRC_FAR:  bz_val = mem_res;
            default:  bz_val = rf_q;
        endcase
    end
    assign taken = id_op.bz & ~stall & (bz_val == '0);

    always_ff @(posedge clk) begin
        if (!rst_n)     pc <= '0;
        else if (taken) pc <= id_j;
        else if (!stall) pc <= pc + JW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || taken) id_ir <= '0;
        else if (!stall)     id_ir <= imem_rdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || stall) ex_op <= '0;
        else                 ex_op <= id_op;
        if (!rst_n) begin
            ex_rr <= '0; ex_rx <= '0; ex_j <= '0; ex_opnd <= '0;
            ex_xm_mem <= 1'b0; ex_xm_wb <= 1'b0;
        end else begin
            ex_rr     <= id_rr;
            ex_rx     <= id_rx;
            ex_j      <= id_j;
            ex_opnd   <= rf_q;
            ex_xm_mem <= xm_ex;   // execute producer moves on to memory
            ex_xm_wb  <= xm_mem;  // memory producer moves on to write-back
        end
    end

    always_comb begin
        if (ex_op.add8 | ex_op.swp8)      ex_steps = SCW'(NSTEP);
        else if (ex_op.add4 | ex_op.swp4) ex_steps = SCW'(1);
        else                              ex_steps = '0;
    end

    cpu5_ex12 #(.DW(DW), .STEP(STEP), .NSTEP(NSTEP)) u_ex (
        .opnd(ex_opnd),
        .near_hit(ex_xm_mem & op_alu(mem_op)), .near_val(mem_res),
        .far_hit(ex_xm_wb & wb_wr),            .far_val(wb_data),
        .steps(ex_steps), .result(ex_res)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_op <= '0; mem_rr <= '0; mem_j <= '0; mem_res <= '0; mem_xm_wb <= 1'b0;
        end else begin
            mem_op    <= ex_op;
            mem_rr    <= ex_rr;
            mem_j     <= ex_j;
            mem_res   <= ex_res;
            mem_xm_wb <= ex_xm_mem;
        end
    end

    // late store-data forwarding for a plain store
    assign mem_sdata  = (mem_op.sw & mem_xm_wb & wb_wr) ? wb_data : mem_res;
    assign dmem_addr  = mem_j;
    assign dmem_wdata = mem_sdata;
    assign dmem_wr    = op_store(mem_op);
    assign dmem_rd    = mem_op.lw;
    assign unused_bits = ^{mem_op.bz, ex_rx};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_wr <= 1'b0; wb_lw <= 1'b0; wb_rr <= '0; wb_res <= '0; wb_ld <= '0;
        end else begin
            wb_wr  <= op_writes(mem_op);
            wb_lw  <= mem_op.lw;
            wb_rr  <= mem_rr;
            wb_res <= mem_res;
            wb_ld  <= dmem_rdata;
        end
    end

    a_r1_fetch_restart: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> imem_addr == '0);
    a_r4_branch_redirect: assert property (@(posedge clk) disable iff (!rst_n)
        taken |=> imem_addr == $past(id_j));
    a_r7_pc_holds: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> imem_addr == $past(imem_addr));
    a_r7_no_load_use_in_ex: assert property (@(posedge clk) disable iff (!rst_n)
        !(op_reads(ex_op) && !ex_op.sw && ex_xm_mem && mem_op.lw));
    a_r10_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dmem_rd, dmem_wr}));
endmodule

// File: tb/cpu5_core_tb.sv
`timescale 1ns/1ps
module cpu5_core_tb;
    localparam int B_MOV = 0, B_BZ = 1, B_ADD4 = 2, B_ADD8 = 3;
    localparam int B_LW = 4, B_SW = 5, B_SWP4 = 6, B_SWP8 = 7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] imem_addr, dmem_addr, dmem_wdata, dmem_rdata;
    logic [31:0] imem_rdata;
    logic        dmem_rd, dmem_wr;

    logic [31:0] imem [64];
    logic [15:0] dmem [1024];

    int checks = 0, fails = 0, cyc = 0, wd = 0;
    int ng = 0, nrd = 0;
    int got_a [32], got_d [32], got_c [32];
    int exp_a [32], exp_d [32], exp_c [32];
    int ne = 0, nld = 0;

    always #2.5 clk = ~clk;

    cpu5_core u_dut (
        .clk(clk), .rst_n(rst_n),
        .imem_addr(imem_addr), .imem_rdata(imem_rdata),
        .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_rdata(dmem_rdata),
        .dmem_rd(dmem_rd), .dmem_wr(dmem_wr)
    );

    assign imem_rdata = imem[imem_addr[5:0]];
    assign dmem_rdata = dmem[dmem_addr[9:0]];

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    // data-memory model and store log, away from the rising edge
    always @(negedge clk) begin
        if (!rst_n) begin
            ng = 0; nrd = 0;
        end else begin
            if (dmem_rd) nrd = nrd + 1;
            if (dmem_wr) begin
                dmem[dmem_addr[9:0]] = dmem_wdata;
                if (ng < 32) begin
                    got_a[ng] = dmem_addr; got_d[ng] = dmem_wdata; got_c[ng] = cyc;
                end
                ng = ng + 1;
            end
        end
    end

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    always @(posedge clk) begin
        wd = wd + 1;
        if (wd > 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog expired act=%0d exp<=150000", wd);
            summary();
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] enc(input int ob, input int rr, input int rx, input int j);
        logic [31:0] w;
        w = 32'(rr & 15) << 20 | 32'(rx & 15) << 16 | 32'(j & 16'hFFFF);
        if (ob >= 0) w = w | (32'd1 << (24 + ob));
        return w;
    endfunction

    // instruction-level reference with hold and branch cost from R4..R9
    task automatic model();
        int pc = 0, tn = 1, tc;
        int rf [16];
        int wt [16];
        int wk [16];   // 0 copy, 1 add, 2 load
        ne = 0; nld = 0;
        for (int i = 0; i < 16; i++) begin rf[i] = 0; wt[i] = -100; wk[i] = 0; end
        for (int s = 0; s < 60; s++) begin
            logic [31:0] ir;
            logic [7:0]  op;
            int rr, rx, j, d;
            ir = imem[pc[5:0]]; op = ir[31:24];
            rr = int'(ir[23:20]); rx = int'(ir[19:16]); j = int'(ir[15:0]);
            tc = tn;
            if (op != 8'd0 && !op[B_LW]) begin
                if (op[B_BZ])      d = (wk[rx] == 2) ? 3 : (wk[rx] == 1) ? 2 : 1;
                else if (op[B_SW]) d = 1;
                else               d = (wk[rx] == 2) ? 2 : 1;
                if (wt[rx] + d > tc) tc = wt[rx] + d;
            end
            tn = tc + 1;
            if (op[B_BZ]) begin
                if (rf[rx] == 0) begin
                    if (j == pc) break;
                    pc = j; tn = tc + 2;
                end else pc = pc + 1;
            end else begin
                if (op[B_MOV])  begin rf[rr] = rf[rx]; wt[rr] = tc; wk[rr] = 0; end
                if (op[B_ADD4]) begin rf[rr] = (rf[rx] + 4) & 16'hFFFF; wt[rr] = tc; wk[rr] = 1; end
                if (op[B_ADD8]) begin rf[rr] = (rf[rx] + 8) & 16'hFFFF; wt[rr] = tc; wk[rr] = 1; end
                if (op[B_LW])   begin rf[rr] = int'(dmem[j[9:0]]); wt[rr] = tc; wk[rr] = 2; nld++; end
                if (op[B_SW] || op[B_SWP4] || op[B_SWP8]) begin
                    exp_a[ne] = j;
                    exp_d[ne] = (rf[rx] + (op[B_SWP4] ? 4 : op[B_SWP8] ? 8 : 0)) & 16'hFFFF;
                    exp_c[ne] = tc + 2;
                    ne++;
                end
                pc = pc + 1;
            end
        end
    endtask

    task automatic run_case(input int pb, input int cb, input int gap, input logic [15:0] seed, input bit first);
        int n = 0, last;
        string vtag, ttag;
        for (int i = 0; i < 64; i++) imem[i] = 32'd0;
        dmem[10'h100] = seed;
        dmem[10'h101] = seed & 16'h00FF;
        imem[n++] = enc(B_LW, 1, 0, 16'h100);
        imem[n++] = enc(B_LW, 4, 0, 16'h101);
        if (pb == B_LW) imem[n++] = enc(B_LW, 2, 0, 16'h101);
        else            imem[n++] = enc(pb, 2, 1, 0);
        for (int g = 0; g < gap; g++) imem[n++] = enc(-1, 0, 0, 0);
        if (cb == B_BZ) begin
            imem[n] = enc(B_BZ, 0, 2, n + 3); n++;
            imem[n++] = enc(B_SW, 0, 1, 16'h201);
            imem[n++] = enc(B_SW, 0, 1, 16'h202);
            imem[n++] = enc(B_SW, 0, 2, 16'h203);
        end else if (cb == B_SW || cb == B_SWP4 || cb == B_SWP8) begin
            imem[n++] = enc(cb, 0, 2, 16'h200);
        end else begin
            imem[n++] = enc(cb, 3, 2, 0);
            imem[n++] = enc(B_SW, 0, 3, 16'h200);
        end
        imem[n++] = enc(B_SW, 0, 2, 16'h204);
        imem[n] = enc(B_BZ, 0, 7, n);

        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        model();
        @(negedge clk);
        if (first) begin
            chk(imem_addr == 16'd0, "R1", "reset fetch address", int'(imem_addr), 0);
            chk(!dmem_wr && !dmem_rd, "R1", "reset strobes", int'({dmem_rd, dmem_wr}), 0);
        end
        rst_n = 1'b1;
        last = exp_c[ne-1];
        while (cyc < last + 6) @(negedge clk);

        vtag = (cb == B_BZ) ? "R4" : (cb == B_MOV || cb == B_ADD4 || cb == B_ADD8) ? "R2" : "R3";
        if (cb == B_BZ)                      ttag = "R8";
        else if (pb == B_LW && cb == B_SW)   ttag = "R6";
        else if (pb == B_LW)                 ttag = "R7";
        else if (gap == 2)                   ttag = "R9";
        else                                 ttag = "R5";

        chk(ng == ne, vtag, "store count", ng, ne);
        chk(nrd == nld, "R10", "load strobe count", nrd, nld);
        for (int i = 0; i < ne && i < ng; i++) begin
            chk(got_a[i] == exp_a[i], vtag, "store address", got_a[i], exp_a[i]);
            chk(got_d[i] == exp_d[i], vtag, "store data", got_d[i], exp_d[i]);
            chk(got_c[i] == exp_c[i], ttag, "store cycle", got_c[i], exp_c[i]);
        end
    endtask

    initial begin
        int prod [4];
        int cons [7];
        logic [15:0] seeds [4];
        bit first = 1'b1;
        prod = '{B_MOV, B_ADD4, B_ADD8, B_LW};
        cons = '{B_MOV, B_ADD4, B_ADD8, B_SW, B_SWP4, B_SWP8, B_BZ};
        seeds = '{16'h0000, 16'hFFFC, 16'hFFF8, 16'h1234};
        for (int i = 0; i < 1024; i++) dmem[i] = 16'd0;
        for (int p = 0; p < 4; p++)
            for (int c = 0; c < 7; c++)
                for (int g = 0; g < 4; g++)
                    for (int s = 0; s < 4; s++) begin
                        run_case(prod[p], cons[c], g, seeds[s], first);
                        first = 1'b0;
                    end
        summary();
        $finish;
    end
endmodule